// File: doc/BRIEF.md
# Dense 24-bit Lane Pack/Unpack Shifter

This block converts vectors between a sparse layout of eight 32-bit lanes and a dense layout in which each element occupies only 24 bits. It is purely combinational. It takes two 256-bit source vectors (an upper source and a lower source), a direction bit and a 2-bit shift code, and produces one 256-bit result in the same evaluation.

In pack direction, the low 24 bits of every lane of both sources are squeezed into two 192-bit dense values. These are placed between 64-bit zero pads to form a 512-bit word, and a 256-bit window is cut out of it. In unpack direction, the two sources are joined into a 512-bit word and a window is cut from it in the same way. The low 192 bits of that window are then spread back into eight 32-bit lanes with zero tops.

Because the window moves in 64-bit steps, a short sequence of operations can stream dense data across consecutive 256-bit words. Three pack operations turn four sparse vectors into three dense words, and four unpack operations turn them back.

Top module: `dense_lane_shifter`

## Requirements
- R1: In pack direction (`unpack_i`=0), the dense form of a source holds bits 23:0 of lane k (source bits 32k+23..32k) at dense bits 24k+23..24k, so lane 0 sits at the least significant end.
- R2: In pack direction, the 512-bit working word is, from most to least significant: 64 zero bits, dense upper source, dense lower source, 64 zero bits.
- R3: The working word is shifted right by 64 times `shift_code_i` (0, 64, 128 or 192 bits). In pack direction `result_o` is the low 256 bits of the shifted word.
- R4: In pack direction with code 0, `result_o[63:0]` is zero. With code 3, `result_o[255:232]` equals bits 23:0 of lane 7 of the upper source.
- R5: In unpack direction (`unpack_i`=1), the working word is {`src_hi_i`, `src_lo_i`}, shifted as in R3, and its low 192 bits are kept.
- R6: In unpack direction, field k (bits 24k+23..24k) of the kept 192 bits becomes bits 23:0 of result lane k, and bits 31:24 of every result lane are zero.
- R7: In pack direction, bits 31:24 of every input lane have no effect on `result_o`.
- R8: `result_o` follows any input change without a clock edge.
- R9: Packing vectors v0..v3 with (upper, lower, code) = (v1,v0,1), (v2,v1,2), (v3,v2,3) gives dense words w0,w1,w2. Unpacking (w1,w0,0), (w1,w0,3), (w2,w1,2) and (any,w2,1) returns the low 24 bits of each lane of v0, v1, v2 and v3 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_hi_i | input | 256 | Upper source vector |
| src_lo_i | input | 256 | Lower source vector |
| unpack_i | input | 1 | Direction: 0 pack, 1 unpack |
| shift_code_i | input | 2 | Window shift in 64-bit steps |
| result_o | output | 256 | Result vector |

## Verification
All four shift codes are driven in both directions with random full-width sources. This separates errors in window placement from errors in lane ordering, because each code exposes a different slice of the dense upper and lower values.

Sources whose lane tops differ only in bits 31:24 show whether those bits leak into packed results. All-zero and all-ones sources expose the padding and the zero-extension.

A four-vector pack-then-unpack stream checks that the 64-bit steps line up across word boundaries. A mid-cycle input change checks that there is no hidden register in the path.

// File: rtl/dense_lane_pkg.sv
package dense_lane_pkg;
    localparam int LANES   = 8;
    localparam int LANE_W  = 32;
    localparam int FIELD_W = 24;
    localparam int STEP_W  = 64;
    localparam int CODE_W  = 2;
    localparam int VEC_W   = LANES * LANE_W;
    localparam int DENSE_W = LANES * FIELD_W;
    localparam int PAD_W   = VEC_W - DENSE_W;
    localparam int CAT_W   = 2 * VEC_W;

    typedef enum logic {
        DIR_PACK   = 1'b0,
        DIR_UNPACK = 1'b1
    } dir_e;
endpackage

// File: rtl/lane_squeeze.sv
module lane_squeeze #(
    parameter int LANES   = 8,
    parameter int LANE_W  = 32,
    parameter int FIELD_W = 24
) (
    input  logic [LANES*LANE_W-1:0]  lanes_i,
    output logic [LANES*FIELD_W-1:0] dense_o
);
    logic [LANES-1:0] unused_tops;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign dense_o[k*FIELD_W +: FIELD_W] = lanes_i[k*LANE_W +: FIELD_W];
        assign unused_tops[k] = ^lanes_i[k*LANE_W+FIELD_W +: LANE_W-FIELD_W];
    end
endmodule

// File: rtl/window_shifter.sv
module window_shifter #(
    parameter int CAT_W  = 512,
    parameter int OUT_W  = 256,
    parameter int STEP_W = 64,
    parameter int CODE_W = 2
) (
    input  logic [CAT_W-1:0]  cat_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [OUT_W-1:0]  win_o
);
    logic [CAT_W-1:0] shifted;
    logic             unused_upper;

    always_comb begin
        shifted = cat_i >> (int'(code_i) * STEP_W);
    end

    assign win_o        = shifted[OUT_W-1:0];
    assign unused_upper = ^shifted[CAT_W-1:OUT_W];

    // R3: code 0 leaves the low window untouched
    always_comb begin
        if (code_i == '0) begin
            p_zero_shift_r3: assert (win_o == cat_i[OUT_W-1:0])
                else $error("window moved with zero shift code");
        end
    end
endmodule

// File: rtl/lane_widen.sv
module lane_widen #(
    parameter int LANES   = 8,
    parameter int LANE_W  = 32,
    parameter int FIELD_W = 24
) (
    input  logic [LANES*FIELD_W-1:0] dense_i,
    output logic [LANES*LANE_W-1:0]  lanes_o
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lanes_o[k*LANE_W +: LANE_W] =
            {{(LANE_W-FIELD_W){1'b0}}, dense_i[k*FIELD_W +: FIELD_W]};
    end
endmodule

// File: rtl/dense_lane_shifter.sv
module dense_lane_shifter
    import dense_lane_pkg::*;
(
    input  logic [VEC_W-1:0]  src_hi_i,
    input  logic [VEC_W-1:0]  src_lo_i,
    input  logic              unpack_i,
    input  logic [CODE_W-1:0] shift_code_i,
    output logic [VEC_W-1:0]  result_o
);
    dir_e               dir;
    logic [DENSE_W-1:0] dense_hi;
    logic [DENSE_W-1:0] dense_lo;
    logic [CAT_W-1:0]   cat_pack;
    logic [CAT_W-1:0]   cat_sel;
    logic [VEC_W-1:0]   window;
    logic [VEC_W-1:0]   widened;
    logic               unused_win_top;

    assign dir = dir_e'(unpack_i);

    lane_squeeze #(.LANES(LANES), .LANE_W(LANE_W), .FIELD_W(FIELD_W)) u_sq_hi (
        .lanes_i (src_hi_i),
        .dense_o (dense_hi)
    );

    lane_squeeze #(.LANES(LANES), .LANE_W(LANE_W), .FIELD_W(FIELD_W)) u_sq_lo (
        .lanes_i (src_lo_i),
        .dense_o (dense_lo)
    );

    assign cat_pack = {{PAD_W{1'b0}}, dense_hi, dense_lo, {PAD_W{1'b0}}};

    always_comb begin
        unique case (dir)
            DIR_PACK:   cat_sel = cat_pack;
            DIR_UNPACK: cat_sel = {src_hi_i, src_lo_i};
            default:    cat_sel = cat_pack;
        endcase
    end

    window_shifter #(.CAT_W(CAT_W), .OUT_W(VEC_W), .STEP_W(STEP_W), .CODE_W(CODE_W)) u_win (
        .cat_i  (cat_sel),
        .code_i (shift_code_i),
        .win_o  (window)
    );

    lane_widen #(.LANES(LANES), .LANE_W(LANE_W), .FIELD_W(FIELD_W)) u_widen (
        .dense_i (window[DENSE_W-1:0]),
        .lanes_o (widened)
    );

    assign unused_win_top = ^window[VEC_W-1:DENSE_W];

    always_comb begin
        unique case (dir)
            DIR_PACK:   result_o = window;
            DIR_UNPACK: result_o = widened;
            default:    result_o = window;
        endcase
    end

    always_comb begin
        if (dir == DIR_PACK && shift_code_i == 2'd0) begin
            p_pack_low_pad_r4: assert (result_o[PAD_W-1:0] == '0)
                else $error("pack code 0 low pad not zero");
        end
        if (dir == DIR_PACK && shift_code_i == 2'd3) begin
            p_pack_top_field_r4: assert (result_o[VEC_W-1 -: FIELD_W] ==
                                         src_hi_i[(LANES-1)*LANE_W +: FIELD_W])
                else $error("pack code 3 top field mismatch");
        end
        if (dir == DIR_UNPACK && shift_code_i == 2'd0) begin
            p_unpack_base_r5: assert (result_o[FIELD_W-1:0] == src_lo_i[FIELD_W-1:0])
                else $error("unpack code 0 lane 0 mismatch");
        end
        if (dir == DIR_UNPACK) begin
            for (int k = 0; k < LANES; k++) begin
                p_unpack_headroom_r6: assert (result_o[k*LANE_W+FIELD_W +: LANE_W-FIELD_W] == '0)
                    else $error("unpack lane top not zero");
            end
        end
    end
endmodule

// File: tb/dense_lane_shifter_bench.sv
module dense_lane_shifter_bench;
    logic         clk = 1'b0;
    logic [255:0] hi, lo;
    logic         unp;
    logic [1:0]   code;
    logic [255:0] res;
    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    dense_lane_shifter u_dense_lane_shifter (
        .src_hi_i     (hi),
        .src_lo_i     (lo),
        .unpack_i     (unp),
        .shift_code_i (code),
        .result_o     (res)
    );

    function automatic logic [255:0] model(logic [255:0] a, logic [255:0] b, logic u, logic [1:0] c);
        logic [511:0] w;
        logic [511:0] s;
        logic [255:0] r;
        w = '0;
        if (!u) begin
            for (int e = 0; e < 8; e++)
                for (int t = 0; t < 24; t++) begin
                    w[64 + e*24 + t]  = b[e*32 + t];
                    w[256 + e*24 + t] = a[e*32 + t];
                end
        end else begin
            w = {a, b};
        end
        s = w;
        for (int n = 0; n < int'(c) * 64; n++) s = {1'b0, s[511:1]};
        if (!u) return s[255:0];
        r = '0;
        for (int e = 0; e < 8; e++)
            for (int t = 0; t < 24; t++) r[e*32 + t] = s[e*24 + t];
        return r;
    endfunction

    function automatic logic [255:0] low24(logic [255:0] v);
        logic [255:0] r;
        r = v;
        for (int e = 0; e < 8; e++) r[e*32+24 +: 8] = 8'h00;
        return r;
    endfunction

    function automatic logic [255:0] rnd256();
        return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(string tag, logic [255:0] got, logic [255:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic apply(logic [255:0] a, logic [255:0] b, logic u, logic [1:0] c);
        @(posedge clk);
        #1;
        hi = a; lo = b; unp = u; code = c;
        @(negedge clk);
    endtask

    task automatic run_vec(string tag, logic [255:0] a, logic [255:0] b, logic u, logic [1:0] c);
        apply(a, b, u, c);
        check(tag, res, model(a, b, u, c));
    endtask

    initial begin
        #4000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [255:0] v0, v1, v2, v3, w0, w1, w2, x, y;
        hi = '0; lo = '0; unp = 1'b0; code = 2'd0;
        // quiet state with zero inputs (R2 pads, R6 zero lanes)
        apply('0, '0, 1'b0, 2'd0);
        check("R2 zero pack", res, '0);
        apply('0, '0, 1'b1, 2'd0);
        check("R6 zero unpack", res, '0);

        // all-ones: padding and zero-extension visible (R2 R4 R6)
        for (int c = 0; c < 4; c++) begin
            run_vec("R2 ones pack", '1, '1, 1'b0, 2'(c));
            run_vec("R6 ones unpack", '1, '1, 1'b1, 2'(c));
        end
        apply('1, '1, 1'b0, 2'd0);
        check("R4 pack low pad", {192'd0, res[63:0]}, '0);

        // ordered lane markers: lane ordering (R1) and window placement (R3, R5)
        x = '0; y = '0;
        for (int e = 0; e < 8; e++) begin
            x[e*32 +: 32] = 32'hA5000000 | (32'h00100000 * e) | 32'h00000011 * (e+1);
            y[e*32 +: 32] = 32'h5A000000 | (32'h00010101 * (e+1));
        end
        apply(x, y, 1'b0, 2'd0);
        check("R1 lane order pack", res[255:64], {
            y[247:224], y[215:192], y[183:160], y[151:128],
            y[119:96],  y[87:64],   y[55:32],   y[23:0]});
        for (int c = 0; c < 4; c++) begin
            run_vec("R3 marker pack", x, y, 1'b0, 2'(c));
            run_vec("R5 marker unpack", x, y, 1'b1, 2'(c));
        end
        apply(x, y, 1'b0, 2'd3);
        check("R4 pack code3 top", {232'd0, res[255:232]}, {232'd0, x[247:224]});

        // R7: lane tops ignored in pack
        for (int c = 0; c < 4; c++) begin
            apply(x, y, 1'b0, 2'(c));
            w0 = res;
            apply(x ^ {8{32'hFF000000}}, y ^ {8{32'hFF000000}}, 1'b0, 2'(c));
            check("R7 tops ignored", res, w0);
        end

        // R8: combinational response mid-cycle
        @(negedge clk);
        hi = x; lo = y; unp = 1'b1; code = 2'd2;
        #1;
        check("R8 comb response", res, model(x, y, 1'b1, 2'd2));
        lo = ~y;
        #1;
        check("R8 comb follow", res, model(x, ~y, 1'b1, 2'd2));

        // R9: stream four vectors through pack then back through unpack
        for (int rep = 0; rep < 4; rep++) begin
            v0 = rnd256(); v1 = rnd256(); v2 = rnd256(); v3 = rnd256();
            apply(v1, v0, 1'b0, 2'd1); w0 = res;
            apply(v2, v1, 1'b0, 2'd2); w1 = res;
            apply(v3, v2, 1'b0, 2'd3); w2 = res;
            apply(w1, w0, 1'b1, 2'd0); check("R9 stream v0", res, low24(v0));
            apply(w1, w0, 1'b1, 2'd3); check("R9 stream v1", res, low24(v1));
            apply(w2, w1, 1'b1, 2'd2); check("R9 stream v2", res, low24(v2));
            apply(rnd256(), w2, 1'b1, 2'd1); check("R9 stream v3", res, low24(v3));
        end

        // random sweep compared every clock (R1 R3 R5 R6)
        for (int n = 0; n < 3000; n++) begin
            run_vec(((n & 1) != 0) ? "R5 R6 random unpack" : "R1 R3 random pack",
                    rnd256(), rnd256(), 1'((n & 1) != 0), 2'($urandom_range(0, 3)));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule